// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the bus cycles that a small 8-bit processor core uses to enter an interrupt handler. It covers four sources: reset, the non-maskable interrupt (NMI), the maskable interrupt (IRQ), and the software break instruction (BRK). The block keeps a register of pending hardware requests. NMI is caught on a falling edge of `nmi_n`. IRQ follows the `irq_n` level, gated by the interrupt-disable flag. Reset and power-on are latched. The core raises `boundary` when it is about to fetch an opcode, and raises `brk_req` once it has decoded a break instruction. In either case the sequencer takes over the bus for six cycles. It pushes the return address and the status byte onto the stack page, or only performs dummy stack reads in the case of reset. It then reads the two vector bytes and hands back the new program counter, the new stack pointer and the flag updates.

The input `cmos_mode` selects between two variants. In the original variant, a BRK that meets a pending NMI is redirected to the NMI vector and absorbs that NMI. The CMOS variant always uses the IRQ/BRK vector for BRK, and it clears the decimal flag on every kind of entry. The core supplies `pc_in`, `sp_in` and `status_in`, and holds them steady until `entry_done`.

Top module: `intr_seq`

## Requirements
- R1: Holding `rst_n` low makes `pend_o` equal 0x10. Within `pend_o`, bit 7 means reset requested (set by `reset_req`), bit 5 means NMI pending (set by a falling edge on `nmi_n`), bit 4 means power-on, and bit 2 means IRQ pending (it equals `irq_n` low and `i_flag` low, as sampled on the last edge).
- R2: While `i_flag` is high, a low `irq_n` leaves `pend_o` bit 2 clear and starts no entry, even with `boundary` held high.
- R3: A hardware request starts an entry only if its `pend_o` bit was already set on the previous clock edge. If `boundary` is held high from the cycle in which `irq_n` falls, the first bus cycle of the entry appears after the third rising edge.
- R4: Among requests that are eligible at the same time, reset or power-on wins over NMI, and NMI wins over IRQ. `brk_req` is accepted only while `boundary` is low.
- R5: A push entry writes `pc_in[15:8]` to address {0x01, SP}, then `pc_in[7:0]` to {0x01, SP-1}, then the status byte to {0x01, SP-2}, one write per cycle. `sp_out` then reports SP-3.
- R6: The status byte pushed for BRK is `status_in` with bits 5 and 4 set. For IRQ and NMI it is `status_in` with bit 5 set and bit 4 clear.
- R7: A reset entry issues three reads at the same three stack addresses in the same order, and no writes.
- R8: The vector low byte is read from 0xFFFA for NMI, 0xFFFC for reset, and 0xFFFE for IRQ and BRK. The high byte is read from the next address in the following cycle. One cycle later `entry_done` pulses, and `new_pc` carries {high, low}.
- R9: With `entry_done`, `set_i` is 1 for IRQ and BRK entries and 0 for NMI and reset entries. `clr_d` is 1 on every entry in CMOS mode (`cmos_mode`=1) and 0 in the original mode.
- R10: In original mode, a BRK taken while `pend_o` bit 5 is set reads the vector at 0xFFFA and clears bit 5. In CMOS mode, the same BRK reads 0xFFFE and bit 5 stays set.
- R11: Taking an NMI entry clears `pend_o` bit 5. Taking a reset entry clears bits 7 and 4.
- R12: An entry lasts exactly six cycles: three stack cycles, two vector reads and one done cycle. `busy` is high for all six, and the bus is idle in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmos_mode | input | 1 | 1 selects the CMOS variant, 0 the original |
| irq_n | input | 1 | Level-sensitive interrupt request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge sensitive |
| reset_req | input | 1 | Requests a reset entry |
| i_flag | input | 1 | Current interrupt-disable flag |
| boundary | input | 1 | Core is at an instruction boundary |
| brk_req | input | 1 | Core has decoded a break instruction |
| pc_in | input | 16 | Return address to push |
| sp_in | input | 8 | Stack pointer at entry |
| status_in | input | 8 | Status byte at entry |
| bus_rdata | input | 8 | Read data from the bus |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| busy | output | 1 | An entry is in progress |
| entry_done | output | 1 | One-cycle pulse marking the end of an entry |
| new_pc | output | 16 | Program counter taken from the vector |
| sp_out | output | 8 | Stack pointer after the entry |
| set_i | output | 1 | Core should set the interrupt-disable flag |
| clr_d | output | 1 | Core should clear the decimal flag |
| pend_o | output | 8 | Pending-request register |

## Verification
Randomised trials mix IRQ, NMI, plain BRK and BRK with an NMI pending, in both variants, with random return addresses, stack pointers and status bytes. These trials separate the push order, the break-bit handling and the vector choice for each source. Directed patterns then cover the rest:
- reset requests raised together with NMI and IRQ, which expose the priority order;
- an IRQ asserted in the same cycle as the boundary, which exposes the one-cycle ageing rule;
- a masked IRQ;
- BRK raised during a boundary;
- BRK with a pending NMI in CMOS mode, which must leave the NMI pending for a later entry.

// File: rtl/intr_seq_pkg.sv
// Package: shared types and bit positions for the interrupt entry sequencer.
// Assumes an 8-bit status byte whose break and always-one bits sit at 4 and 5.
package intr_seq_pkg;

    // Source of an entry, in no particular order (priority lives in intr_seq_sel).
    typedef enum logic [1:0] {
        SRC_RST,
        SRC_NMI,
        SRC_IRQ,
        SRC_BRK
    } src_e;

    // One state per bus cycle of an entry.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_PUSH_P,
        ST_VEC_L,
        ST_VEC_H,
        ST_DONE
    } st_e;

    // Bit positions in the pending-request register.
    localparam int PB_RST = 7;
    localparam int PB_NMI = 5;
    localparam int PB_PWR = 4;
    localparam int PB_IRQ = 2;

    // Bit positions in the status byte.
    localparam int SB_ONE = 5;
    localparam int SB_BRK = 4;

endpackage

// File: rtl/intr_seq_pend.sv
// Module: pending-request register.
// Latches reset and NMI (NMI on a falling edge of nmi_n) and samples the
// unmasked IRQ level every cycle. It also produces an aged copy, so that a
// request only counts as eligible once it has been held for a full cycle.
// Assumes clr_* pulse for one cycle when the matching entry starts.
module intr_seq_pend
    import intr_seq_pkg::*;
#(
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_n,
    input  logic          nmi_n,
    input  logic          reset_req,
    input  logic          i_flag,
    input  logic          clr_rst,
    input  logic          clr_nmi,
    output logic [PW-1:0] pend,
    output logic [PW-1:0] ripe
);

    logic [PW-1:0] pend_d;
    logic          nmi_q;

    // Update the pending bits and their one-cycle-old copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend         <= '0;
            pend[PB_PWR] <= 1'b1;
            pend_d       <= '0;
            nmi_q        <= 1'b1;
        end else begin
            nmi_q        <= nmi_n;
            pend_d       <= pend;
            pend[PB_RST] <= reset_req | (pend[PB_RST] & ~clr_rst);
            pend[PB_PWR] <= pend[PB_PWR] & ~clr_rst;
            pend[PB_NMI] <= (nmi_q & ~nmi_n) | (pend[PB_NMI] & ~clr_nmi);
            pend[PB_IRQ] <= ~irq_n & ~i_flag;
        end
    end

    // A request is eligible once it has been seen on two consecutive edges.
    always_comb ripe = pend & pend_d;

endmodule

// File: rtl/intr_seq_sel.sv
// Module: source and vector selection.
// At a boundary it picks the highest-priority eligible hardware request;
// otherwise it accepts a break request. Purely combinational.
// Assumes it is only consulted while the sequencer is idle.
module intr_seq_sel
    import intr_seq_pkg::*;
#(
    parameter int unsigned          AW       = 16,
    parameter int unsigned          PW       = 8,
    parameter logic [AW-1:0]        VEC_BASE = 16'hFFFA
) (
    input  logic          idle,
    input  logic          boundary,
    input  logic          brk_req,
    input  logic          cmos_mode,
    input  logic [PW-1:0] pend,
    input  logic [PW-1:0] ripe,
    output logic          start,
    output src_e          src,
    output logic [AW-1:0] vec,
    output logic          clr_rst,
    output logic          clr_nmi
);

    localparam logic [AW-1:0] VEC_NMI = VEC_BASE;
    localparam logic [AW-1:0] VEC_RST = VEC_BASE + AW'(2);
    localparam logic [AW-1:0] VEC_IRQ = VEC_BASE + AW'(4);

    logic steal;

    // Prioritise reset/power-on, then NMI, then IRQ; BRK only off-boundary.
    always_comb begin
        start = 1'b0;
        src   = SRC_IRQ;
        vec   = VEC_IRQ;
        steal = 1'b0;
        if (idle) begin
            if (boundary) begin
                if (ripe[PB_RST] | ripe[PB_PWR]) begin
                    start = 1'b1;
                    src   = SRC_RST;
                    vec   = VEC_RST;
                end else if (ripe[PB_NMI]) begin
                    start = 1'b1;
                    src   = SRC_NMI;
                    vec   = VEC_NMI;
                end else if (ripe[PB_IRQ]) begin
                    start = 1'b1;
                end
            end else if (brk_req) begin
                start = 1'b1;
                src   = SRC_BRK;
                if (!cmos_mode && pend[PB_NMI]) begin
                    vec   = VEC_NMI;
                    steal = 1'b1;
                end
            end
        end
    end

    // Tell the pending register which latched requests this entry consumes.
    always_comb begin
        clr_rst = start && (src == SRC_RST);
        clr_nmi = start && ((src == SRC_NMI) || steal);
    end

endmodule

// File: rtl/intr_seq_fsm.sv
// Module: bus-cycle sequencer for one entry.
// Captures the entry context on start, then runs three stack cycles
// (writes, or reads for reset), two vector reads and a done cycle.
// Assumes a combinational read path: bus_rdata is valid in the read cycle.
module intr_seq_fsm
    import intr_seq_pkg::*;
#(
    parameter int unsigned          AW         = 16,
    parameter int unsigned          DW         = 8,
    parameter logic [AW-DW-1:0]     STACK_PAGE = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  src_e          src,
    input  logic [AW-1:0] vec,
    input  logic          cmos_mode,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] bus_rdata,
    output logic          idle,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          entry_done,
    output logic [AW-1:0] new_pc,
    output logic [DW-1:0] sp_out,
    output logic          set_i,
    output logic          clr_d
);

    st_e              state;
    src_e             src_q;
    logic [AW-1:0]    vec_q;
    logic [AW-1:0]    pc_q;
    logic [DW-1:0]    sp_q;
    logic [DW-1:0]    st_q;
    logic             cmos_q;
    logic [DW-1:0]    lo_q;
    logic [AW-DW-1:0] hi_q;
    logic             push_st;

    // Advance one state per cycle; capture context on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            src_q  <= SRC_RST;
            vec_q  <= '0;
            pc_q   <= '0;
            sp_q   <= '0;
            st_q   <= '0;
            cmos_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_PUSH_H;
                    src_q  <= src;
                    vec_q  <= vec;
                    pc_q   <= pc_in;
                    sp_q   <= sp_in;
                    cmos_q <= cmos_mode;
                    st_q   <= status_in;
                    st_q[SB_ONE] <= 1'b1;
                    st_q[SB_BRK] <= (src == SRC_BRK);
                end
                ST_PUSH_H: begin state <= ST_PUSH_L; sp_q <= sp_q - DW'(1); end
                ST_PUSH_L: begin state <= ST_PUSH_P; sp_q <= sp_q - DW'(1); end
                ST_PUSH_P: begin state <= ST_VEC_L;  sp_q <= sp_q - DW'(1); end
                ST_VEC_L:  begin state <= ST_VEC_H;  lo_q <= bus_rdata; end
                ST_VEC_H:  begin state <= ST_DONE;   hi_q <= bus_rdata[AW-DW-1:0]; end
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // The stack cycles share one address form; reset turns them into reads.
    always_comb push_st = (state == ST_PUSH_H) || (state == ST_PUSH_L) ||
                          (state == ST_PUSH_P);

    // Drive the bus and the completion outputs for the current state.
    always_comb begin
        bus_rd     = 1'b0;
        bus_wr     = 1'b0;
        bus_addr   = '0;
        bus_wdata  = '0;
        entry_done = 1'b0;
        set_i      = 1'b0;
        clr_d      = 1'b0;
        if (push_st) begin
            bus_addr = {STACK_PAGE, sp_q};
            if (src_q == SRC_RST) begin
                bus_rd = 1'b1;
            end else begin
                bus_wr = 1'b1;
                unique case (state)
                    ST_PUSH_H: bus_wdata = pc_q[AW-1:AW-DW];
                    ST_PUSH_L: bus_wdata = pc_q[DW-1:0];
                    default:   bus_wdata = st_q;
                endcase
            end
        end else if (state == ST_VEC_L) begin
            bus_rd   = 1'b1;
            bus_addr = vec_q;
        end else if (state == ST_VEC_H) begin
            bus_rd   = 1'b1;
            bus_addr = vec_q + AW'(1);
        end else if (state == ST_DONE) begin
            entry_done = 1'b1;
            set_i      = (src_q == SRC_IRQ) || (src_q == SRC_BRK);
            clr_d      = cmos_q;
        end
    end

    always_comb begin
        idle   = (state == ST_IDLE);
        new_pc = {hi_q, lo_q};
        sp_out = sp_q;
    end

endmodule

// File: rtl/intr_seq.sv
// Module: interrupt entry sequencer top.
// Ties the pending register, the source selector and the bus sequencer
// together. Assumes the core holds pc_in, sp_in and status_in steady
// from the start edge until entry_done.
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int unsigned      AW         = 16,
    parameter int unsigned      DW         = 8,
    parameter logic [AW-DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [AW-1:0]    VEC_BASE   = 16'hFFFA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmos_mode,
    input  logic          irq_n,
    input  logic          nmi_n,
    input  logic          reset_req,
    input  logic          i_flag,
    input  logic          boundary,
    input  logic          brk_req,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          busy,
    output logic          entry_done,
    output logic [AW-1:0] new_pc,
    output logic [DW-1:0] sp_out,
    output logic          set_i,
    output logic          clr_d,
    output logic [DW-1:0] pend_o
);

    logic [DW-1:0] pend;
    logic [DW-1:0] ripe;
    logic          idle;
    logic          start;
    src_e          src;
    logic [AW-1:0] vec;
    logic          clr_rst;
    logic          clr_nmi;

    intr_seq_pend #(.PW(DW)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_n     (irq_n),
        .nmi_n     (nmi_n),
        .reset_req (reset_req),
        .i_flag    (i_flag),
        .clr_rst   (clr_rst),
        .clr_nmi   (clr_nmi),
        .pend      (pend),
        .ripe      (ripe)
    );

    intr_seq_sel #(.AW(AW), .PW(DW), .VEC_BASE(VEC_BASE)) u_sel (
        .idle      (idle),
        .boundary  (boundary),
        .brk_req   (brk_req),
        .cmos_mode (cmos_mode),
        .pend      (pend),
        .ripe      (ripe),
        .start     (start),
        .src       (src),
        .vec       (vec),
        .clr_rst   (clr_rst),
        .clr_nmi   (clr_nmi)
    );

    intr_seq_fsm #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .src        (src),
        .vec        (vec),
        .cmos_mode  (cmos_mode),
        .pc_in      (pc_in),
        .sp_in      (sp_in),
        .status_in  (status_in),
        .bus_rdata  (bus_rdata),
        .idle       (idle),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .entry_done (entry_done),
        .new_pc     (new_pc),
        .sp_out     (sp_out),
        .set_i      (set_i),
        .clr_d      (clr_d)
    );

    always_comb begin
        busy   = ~idle;
        pend_o = pend;
    end

endmodule

// File: rtl/intr_seq_chk.sv
// Module: protocol checker for intr_seq, attached through bind.
// Watches only the top-level ports.
module intr_seq_chk #(
    parameter int unsigned      AW         = 16,
    parameter int unsigned      DW         = 8,
    parameter logic [AW-DW-1:0] STACK_PAGE = 8'h01
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic          entry_done,
    input logic          set_i,
    input logic          clr_d,
    input logic [DW-1:0] pend_o
);

    // R12: a cycle never reads and writes at once.
    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R5: every push lands in the stack page.
    a_r5_push_in_stack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr[AW-1:DW] == STACK_PAGE));

    // R5: consecutive pushes go one address downward.
    a_r5_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (!bus_wr || (bus_addr[DW-1:0] == $past(bus_addr[DW-1:0]) - DW'(1))));

    // R8: completion follows a vector read.
    a_r8_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> $past(bus_rd));

    // R12: completion is a single-cycle pulse.
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |=> !entry_done);

    // R9: flag strobes appear only with completion.
    a_r9_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i || clr_d) |-> entry_done);

    // R1: reset leaves only the power-on bit pending.
    a_r1_power_on: assert property (@(posedge clk)
        !rst_n |=> (pend_o == DW'(8'h10)));

endmodule

bind intr_seq intr_seq_chk #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (.*);

// File: tb/sim_intr_seq.sv
`timescale 1ns/1ps
module sim_intr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmos_mode = 1'b0;
    logic        irq_n = 1'b1;
    logic        nmi_n = 1'b1;
    logic        reset_req = 1'b0;
    logic        i_flag = 1'b0;
    logic        boundary = 1'b0;
    logic        brk_req = 1'b0;
    logic [15:0] pc_in = 16'h1234;
    logic [7:0]  sp_in = 8'hFD;
    logic [7:0]  status_in = 8'h00;
    logic [7:0]  bus_rdata;
    logic        bus_rd, bus_wr, busy, entry_done, set_i, clr_d;
    logic [15:0] bus_addr, new_pc;
    logic [7:0]  bus_wdata, sp_out, pend_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam int K_RST = 0;
    localparam int K_NMI = 1;
    localparam int K_IRQ = 2;
    localparam int K_BRK = 3;

    always #5 clk = ~clk;

    // Bus model: vector byte is a fixed function of the address.
    function automatic logic [7:0] vbyte(input logic [15:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    assign bus_rdata = bus_rd ? vbyte(bus_addr) : 8'h00;

    intr_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmos_mode(cmos_mode), .irq_n(irq_n),
        .nmi_n(nmi_n), .reset_req(reset_req), .i_flag(i_flag),
        .boundary(boundary), .brk_req(brk_req), .pc_in(pc_in), .sp_in(sp_in),
        .status_in(status_in), .bus_rdata(bus_rdata), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .entry_done(entry_done), .new_pc(new_pc),
        .sp_out(sp_out), .set_i(set_i), .clr_d(clr_d), .pend_o(pend_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] vec_of(input int kind, input bit cm, input bit nmi_p);
        case (kind)
            K_RST:   return 16'hFFFC;
            K_NMI:   return 16'hFFFA;
            K_IRQ:   return 16'hFFFE;
            default: return (!cm && nmi_p) ? 16'hFFFA : 16'hFFFE;
        endcase
    endfunction

    function automatic logic [7:0] push_status(input int kind, input logic [7:0] st);
        if (kind == K_BRK) return st | 8'h30;
        return (st | 8'h20) & 8'hEF;
    endfunction

    // Called at the negedge right after the start edge; checks all six cycles plus one.
    task automatic expect_entry(input int kind, input bit cm, input logic [15:0] vec);
        logic [7:0]  sp = sp_in;
        logic [15:0] pc = pc_in;
        logic [7:0]  exp_b [3];
        exp_b[0] = pc[15:8];
        exp_b[1] = pc[7:0];
        exp_b[2] = push_status(kind, status_in);
        for (int c = 0; c < 3; c++) begin
            logic [15:0] a = {8'h01, sp - 8'(c)};
            if (kind == K_RST) begin
                chk(bus_rd && !bus_wr && bus_addr == a, "R7 stack read",
                    {bus_rd, bus_wr, bus_addr}, {2'b10, a});
            end else begin
                chk(bus_wr && bus_addr == a, "R5 push address", {bus_wr, bus_addr}, {1'b1, a});
                chk(bus_wdata == exp_b[c], (c == 2) ? "R6 status byte" : "R5 push data",
                    bus_wdata, exp_b[c]);
            end
            chk(busy, "R12 busy", busy, 1);
            @(negedge clk);
        end
        chk(bus_rd && bus_addr == vec, "R8 vector low", bus_addr, vec);
        @(negedge clk);
        chk(bus_rd && bus_addr == vec + 16'd1, "R8 vector high", bus_addr, vec + 16'd1);
        @(negedge clk);
        chk(entry_done && new_pc == {vbyte(vec + 16'd1), vbyte(vec)}, "R8 new pc",
            new_pc, {vbyte(vec + 16'd1), vbyte(vec)});
        chk(sp_out == sp - 8'd3, "R5 sp_out", sp_out, sp - 8'd3);
        chk(set_i == (kind == K_IRQ || kind == K_BRK) && clr_d == cm, "R9 flag strobes",
            {set_i, clr_d}, {(kind == K_IRQ || kind == K_BRK), cm});
        @(negedge clk);
        chk(!busy && !bus_rd && !bus_wr && !entry_done, "R12 idle after",
            {busy, bus_rd, bus_wr, entry_done}, 0);
    endtask

    task automatic pulse_boundary();
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
    endtask

    task automatic randomise_ctx();
        pc_in     = 16'($urandom);
        sp_in     = 8'($urandom_range(8'h10, 8'hFF));
        status_in = 8'($urandom);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(pend_o == 8'h10, "R1 reset pending", pend_o, 8'h10);
        chk(!bus_rd && !bus_wr && !busy, "R12 reset idle", {bus_rd, bus_wr, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Power-on entry.
        pulse_boundary();
        expect_entry(K_RST, 1'b0, 16'hFFFC);
        chk(pend_o == 8'h00, "R11 power-on cleared", pend_o, 0);

        // R3: IRQ arrives with boundary already high.
        irq_n = 1'b0; boundary = 1'b1;
        @(negedge clk);
        chk(!bus_wr, "R3 not after one edge", bus_wr, 0);
        @(negedge clk);
        chk(!bus_wr, "R3 not after two edges", bus_wr, 0);
        chk(pend_o[2], "R1 irq bit", pend_o, 8'h04);
        @(negedge clk);
        boundary = 1'b0; irq_n = 1'b1;
        expect_entry(K_IRQ, 1'b0, 16'hFFFE);

        // R2: masked IRQ.
        irq_n = 1'b0; i_flag = 1'b1; boundary = 1'b1;
        repeat (4) @(negedge clk);
        chk(!busy && !bus_wr && !bus_rd, "R2 masked no entry", busy, 0);
        chk(pend_o[2] == 1'b0, "R2 masked pend bit", pend_o, 0);
        boundary = 1'b0; irq_n = 1'b1; i_flag = 1'b0;
        @(negedge clk);

        // R4: BRK ignored during a boundary.
        boundary = 1'b1; brk_req = 1'b1;
        @(negedge clk);
        boundary = 1'b0; brk_req = 1'b0;
        chk(!busy && !bus_wr, "R4 brk ignored on boundary", busy, 0);

        // R4: reset, NMI and IRQ together.
        for (int m = 0; m < 2; m++) begin
            cmos_mode = m[0];
            reset_req = 1'b1; nmi_n = 1'b0; irq_n = 1'b0;
            @(negedge clk);
            reset_req = 1'b0; nmi_n = 1'b1;
            @(negedge clk);
            chk(pend_o == 8'hA4, "R1 pending bits", pend_o, 8'hA4);
            pulse_boundary();
            expect_entry(K_RST, cmos_mode, 16'hFFFC);
            chk(pend_o[7] == 1'b0 && pend_o[5], "R11 reset cleared", pend_o, 8'h24);
            pulse_boundary();
            expect_entry(K_NMI, cmos_mode, 16'hFFFA);
            chk(pend_o[5] == 1'b0, "R11 nmi cleared", pend_o, 8'h04);
            pulse_boundary();
            irq_n = 1'b1;
            expect_entry(K_IRQ, cmos_mode, 16'hFFFE);
        end

        // Random mix of entries in both variants.
        for (int it = 0; it < 60; it++) begin
            int kind;
            kind = int'($urandom_range(0, 4));
            cmos_mode = 1'($urandom);
            randomise_ctx();
            if (kind == 0) begin
                irq_n = 1'b0;
                repeat (2) @(negedge clk);
                pulse_boundary();
                irq_n = 1'b1;
                expect_entry(K_IRQ, cmos_mode, 16'hFFFE);
            end else if (kind == 1) begin
                nmi_n = 1'b0;
                @(negedge clk);
                nmi_n = 1'b1;
                @(negedge clk);
                pulse_boundary();
                expect_entry(K_NMI, cmos_mode, 16'hFFFA);
            end else if (kind == 2) begin
                brk_req = 1'b1;
                @(negedge clk);
                brk_req = 1'b0;
                expect_entry(K_BRK, cmos_mode, 16'hFFFE);
            end else if (kind == 3) begin
                // R10: BRK meets a pending NMI.
                nmi_n = 1'b0;
                @(negedge clk);
                nmi_n = 1'b1;
                @(negedge clk);
                brk_req = 1'b1;
                @(negedge clk);
                brk_req = 1'b0;
                expect_entry(K_BRK, cmos_mode, vec_of(K_BRK, cmos_mode, 1'b1));
                chk(pend_o[5] == cmos_mode, "R10 nmi pending after brk",
                    pend_o[5], cmos_mode);
                if (cmos_mode) begin
                    pulse_boundary();
                    expect_entry(K_NMI, 1'b1, 16'hFFFA);
                end
            end else begin
                reset_req = 1'b1;
                @(negedge clk);
                reset_req = 1'b0;
                @(negedge clk);
                pulse_boundary();
                expect_entry(K_RST, cmos_mode, 16'hFFFC);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule